// File: doc/BRIEF.md
# Base and Length Address Relocation Unit

This block turns the addresses issued by a running program into physical memory addresses. Every program is linked as if it starts at address zero. The unit treats each address the program issues as an offset and adds a base value to it. A second value, the length, bounds the region the program may touch. If an address lands beyond the base plus the length, or if the 32-bit addition carries out, the unit raises a protection fault. While the fault is raised, the memory strobe stays off, but the relocated address is still placed on the output.

Privileged software sets the two values through a small write port: a select bit picks the value and a write-enable stores the data. A context switch is done by writing the incoming program's base and length. Each program therefore sees memory as its own, starting at zero. Translation is combinational from the stored values and the request. The result passes through a single output register, so a request sampled at one clock edge is answered after that edge.

Top module: `reloc_unit`

## Requirements
- R1: After synchronous reset, `rsp_valid` and `mem_strobe` are 0, and both the stored base and the stored length are 0. With those values, offset 0 translates to address 0 without a fault, and offset 1 faults.
- R2: When `cfg_we` is 1 at a rising clock edge, `cfg_wdata` is stored into the base if `cfg_sel` is 0, or into the length if `cfg_sel` is 1. The other value is left unchanged.
- R3: The response address `rsp_paddr` equals the stored base plus `req_vaddr`, modulo 2^32.
- R4: `rsp_fault` is 1 when the relocated address, taken as a 33-bit sum, is strictly greater than the 33-bit sum of base and length. An offset exactly equal to the length does not fault.
- R5: A carry out of the 32-bit addition of base and offset always sets `rsp_fault`.
- R6: A request sampled with `req_valid` 1 at a rising edge produces `rsp_valid` 1, together with its address and fault flag, right after that edge, for exactly one cycle per request.
- R7: `mem_strobe` is 1 exactly when `rsp_valid` is 1 and `rsp_fault` is 0. A faulting response still carries the relocated address on `rsp_paddr`.
- R8: A cycle with `req_valid` 0 yields `rsp_valid` 0 and `mem_strobe` 0. `rsp_paddr` and `rsp_fault` keep their previous values.
- R9: A configuration write and a request sampled at the same edge are handled as follows: the request is translated with the values held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Privileged write enable for the base or the length |
| cfg_sel | input | 1 | Select: 0 base, 1 length |
| cfg_wdata | input | 32 | Value to store |
| req_valid | input | 1 | Request present this cycle |
| req_vaddr | input | 32 | Program-relative address (offset) |
| rsp_valid | output | 1 | Response present |
| rsp_paddr | output | 32 | Relocated physical address |
| rsp_fault | output | 1 | Protection fault for this response |
| mem_strobe | output | 1 | Memory access strobe, suppressed on a fault |

## Verification
Every response is due in the cycle after the edge that samples its request. The bench drives inputs on the falling edge, lets one rising edge pass, and reads `rsp_valid`, `rsp_paddr`, `rsp_fault` and `mem_strobe` on the next falling edge. A configuration write takes effect at the edge that samples it, so the bench updates its own model only after that edge. This is also why a write and a request sampled together are checked against the old values. Idle cycles are checked one and two cycles after the last request, to confirm that the held address and fault flag do not change.

// File: rtl/reloc_pkg.sv
package reloc_pkg;
  localparam int unsigned RELOC_ADDR_W = 32;

  typedef enum logic [0:0] {
    CFG_BASE  = 1'b0,
    CFG_LIMIT = 1'b1
  } cfg_sel_e;
endpackage

// File: rtl/reloc_cfg_regs.sv
module reloc_cfg_regs
  import reloc_pkg::*;
#(
  parameter int unsigned ADDR_W = RELOC_ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic              sel,
  input  logic [ADDR_W-1:0] wdata,
  output logic [ADDR_W-1:0] base_o,
  output logic [ADDR_W-1:0] limit_o
);
  localparam int unsigned NREG = 2;

  logic [ADDR_W-1:0] regs_q [NREG];
  logic [NREG-1:0]   hit;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    assign hit[g] = we && (sel == g[0]);
    always_ff @(posedge clk) begin
      if (rst) begin
        regs_q[g] <= '0;
      end else if (hit[g]) begin
        regs_q[g] <= wdata;
      end
    end
  end

  assign base_o  = regs_q[CFG_BASE];
  assign limit_o = regs_q[CFG_LIMIT];
endmodule

// File: rtl/reloc_xlate.sv
module reloc_xlate #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] limit_i,
  input  logic [ADDR_W-1:0] vaddr_i,
  output logic [ADDR_W-1:0] paddr_o,
  output logic              fault_o
);
  localparam int unsigned WIDE_W = ADDR_W + 1;

  logic [WIDE_W-1:0] sum_w;
  logic [WIDE_W-1:0] bound_w;
  logic              carry;
  logic              over_bound;

  always_comb begin
    sum_w      = {1'b0, base_i} + {1'b0, vaddr_i};
    bound_w    = {1'b0, base_i} + {1'b0, limit_i};
    carry      = sum_w[ADDR_W];
    over_bound = sum_w > bound_w;
    paddr_o    = sum_w[ADDR_W-1:0];
    fault_o    = carry | over_bound;
  end
endmodule

// File: rtl/reloc_rsp_stage.sv
module reloc_rsp_stage #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic              fault_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] paddr_o,
  output logic              fault_o,
  output logic              strobe_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o  <= 1'b0;
      strobe_o <= 1'b0;
      paddr_o  <= '0;
      fault_o  <= 1'b0;
    end else begin
      valid_o  <= valid_i;
      strobe_o <= valid_i & ~fault_i;
      if (valid_i) begin
        paddr_o <= paddr_i;
        fault_o <= fault_i;
      end
    end
  end
endmodule

// File: rtl/reloc_unit.sv
module reloc_unit
  import reloc_pkg::*;
#(
  parameter int unsigned ADDR_W = RELOC_ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_vaddr,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] rsp_paddr,
  output logic              rsp_fault,
  output logic              mem_strobe
);
  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] limit_q;
  logic [ADDR_W-1:0] xl_paddr;
  logic              xl_fault;

  reloc_cfg_regs #(.ADDR_W(ADDR_W)) i_cfg (
    .clk     (clk),
    .rst     (rst),
    .we      (cfg_we),
    .sel     (cfg_sel),
    .wdata   (cfg_wdata),
    .base_o  (base_q),
    .limit_o (limit_q)
  );

  reloc_xlate #(.ADDR_W(ADDR_W)) i_xlate (
    .base_i  (base_q),
    .limit_i (limit_q),
    .vaddr_i (req_vaddr),
    .paddr_o (xl_paddr),
    .fault_o (xl_fault)
  );

  reloc_rsp_stage #(.ADDR_W(ADDR_W)) i_rsp (
    .clk      (clk),
    .rst      (rst),
    .valid_i  (req_valid),
    .paddr_i  (xl_paddr),
    .fault_i  (xl_fault),
    .valid_o  (rsp_valid),
    .paddr_o  (rsp_paddr),
    .fault_o  (rsp_fault),
    .strobe_o (mem_strobe)
  );
endmodule

// File: rtl/reloc_unit_chk.sv
module reloc_unit_chk #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_vaddr,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] rsp_paddr,
  input logic              rsp_fault,
  input logic              mem_strobe,
  input logic [ADDR_W-1:0] base_q,
  input logic [ADDR_W-1:0] limit_q
);
  logic [ADDR_W:0]   chk_sum;
  logic [ADDR_W-1:0] chk_low;
  logic              chk_carry;

  assign chk_sum   = {1'b0, base_q} + {1'b0, req_vaddr};
  assign chk_low   = chk_sum[ADDR_W-1:0];
  assign chk_carry = chk_sum[ADDR_W];

  // R6
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    (!rst && req_valid) |=> rsp_valid);

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!rst && !req_valid) |=> (!rsp_valid && !mem_strobe && $stable(rsp_paddr) && $stable(rsp_fault)));

  // R3
  paddr_sum_chk: assert property (@(posedge clk) disable iff (rst)
    (!rst && req_valid) |=> (rsp_paddr == $past(chk_low)));

  // R7
  strobe_gate_chk: assert property (@(posedge clk) disable iff (rst)
    mem_strobe == (rsp_valid && !rsp_fault));

  // R4
  within_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (!rst && req_valid && !chk_carry && req_vaddr <= limit_q) |=> !rsp_fault);

  // R4
  beyond_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (!rst && req_valid && req_vaddr > limit_q) |=> rsp_fault);

  // R5
  carry_fault_chk: assert property (@(posedge clk) disable iff (rst)
    (!rst && req_valid && chk_carry) |=> rsp_fault);
endmodule

bind reloc_unit reloc_unit_chk #(.ADDR_W(ADDR_W)) i_reloc_unit_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_vaddr  (req_vaddr),
  .rsp_valid  (rsp_valid),
  .rsp_paddr  (rsp_paddr),
  .rsp_fault  (rsp_fault),
  .mem_strobe (mem_strobe),
  .base_q     (base_q),
  .limit_q    (limit_q)
);

// File: tb/test_reloc_unit.sv
module test_reloc_unit;
  localparam int unsigned AW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic          cfg_sel = 1'b0;
  logic [AW-1:0] cfg_wdata = '0;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_vaddr = '0;
  logic          rsp_valid;
  logic [AW-1:0] rsp_paddr;
  logic          rsp_fault;
  logic          mem_strobe;

  int unsigned n_vec = 0;
  int unsigned n_bad = 0;
  logic [AW-1:0] m_base = '0;
  logic [AW-1:0] m_limit = '0;
  logic [AW-1:0] last_pa;
  logic          last_f;

  always #5 clk = ~clk;

  reloc_unit #(.ADDR_W(AW)) i_reloc_unit (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_vaddr(req_vaddr), .rsp_valid(rsp_valid),
    .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault), .mem_strobe(mem_strobe)
  );

  function automatic logic [AW-1:0] exp_pa(logic [AW-1:0] b, logic [AW-1:0] v);
    return b + v;
  endfunction

  function automatic logic exp_flt(logic [AW-1:0] b, logic [AW-1:0] l, logic [AW-1:0] v);
    logic [AW:0] s;
    logic [AW:0] bnd;
    s   = {1'b0, b} + {1'b0, v};
    bnd = {1'b0, b} + {1'b0, l};
    return s[AW] || (s > bnd);
  endfunction

  task automatic chk(string req, logic [AW-1:0] act, logic [AW-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_cfg(logic sel, logic [AW-1:0] d);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (sel) m_limit = d; else m_base = d;
  endtask

  // drive at negedge, response registered at next posedge, check at following negedge
  task automatic do_req(logic [AW-1:0] v, string tag);
    logic f;
    req_valid = 1'b1; req_vaddr = v;
    @(negedge clk);
    req_valid = 1'b0;
    f = exp_flt(m_base, m_limit, v);
    chk({tag, " R6 valid"}, AW'(rsp_valid), AW'(1));
    chk({tag, " R3 paddr"}, rsp_paddr, exp_pa(m_base, v));
    chk({tag, " R4/R5 fault"}, AW'(rsp_fault), AW'(f));
    chk({tag, " R7 strobe"}, AW'(mem_strobe), AW'(!f));
    last_pa = exp_pa(m_base, v);
    last_f  = f;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h0000_5eed));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 valid in reset", AW'(rsp_valid), AW'(0));
    chk("R1 strobe in reset", AW'(mem_strobe), AW'(0));
    rst = 1'b0;
    @(negedge clk);
    chk("R1 valid after reset", AW'(rsp_valid), AW'(0));
    do_req(32'd0, "R1 zero offset");
    do_req(32'd1, "R1 offset one");

    // R2 base then length
    wr_cfg(1'b0, 32'h0001_0000);
    wr_cfg(1'b1, 32'h0000_1000);
    do_req(32'h0000_0234, "R2 inside");
    do_req(32'h0000_1000, "R4 at bound");
    do_req(32'h0000_1001, "R4 one past");
    chk("R7 paddr on fault", rsp_paddr, 32'h0001_1001);

    // R8 idle hold
    @(negedge clk);
    chk("R8 idle valid", AW'(rsp_valid), AW'(0));
    chk("R8 idle strobe", AW'(mem_strobe), AW'(0));
    chk("R8 paddr hold", rsp_paddr, last_pa);
    chk("R8 fault hold", AW'(rsp_fault), AW'(last_f));
    @(negedge clk);
    chk("R8 paddr hold 2", rsp_paddr, last_pa);

    // R5 carry
    wr_cfg(1'b0, 32'hFFFF_F000);
    wr_cfg(1'b1, 32'hFFFF_FFFF);
    do_req(32'h0000_0FFF, "R5 top no carry");
    do_req(32'h0000_1000, "R5 carry");
    do_req(32'h8000_0000, "R5 carry big");

    // R2 length write leaves base
    wr_cfg(1'b1, 32'h0000_0010);
    do_req(32'h0000_0010, "R2 base kept");

    // R9 write and request together
    m_base = 32'h0000_4000;
    m_limit = 32'h0000_0100;
    wr_cfg(1'b0, m_base);
    wr_cfg(1'b1, m_limit);
    cfg_we = 1'b1; cfg_sel = 1'b0; cfg_wdata = 32'h0009_0000;
    req_valid = 1'b1; req_vaddr = 32'h0000_0020;
    @(negedge clk);
    cfg_we = 1'b0; req_valid = 1'b0;
    chk("R9 old base used", rsp_paddr, 32'h0000_4020);
    chk("R9 no fault", AW'(rsp_fault), AW'(0));
    m_base = 32'h0009_0000;
    do_req(32'h0000_0020, "R9 new base after");

    // back-to-back requests
    req_valid = 1'b1; req_vaddr = 32'h0000_0001;
    @(negedge clk);
    chk("R6 b2b first", rsp_paddr, 32'h0009_0001);
    req_vaddr = 32'h0000_0200;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R6 b2b second", rsp_paddr, 32'h0009_0200);
    chk("R4 b2b fault", AW'(rsp_fault), AW'(1));

    // random mix
    for (int i = 0; i < 300; i++) begin
      logic [AW-1:0] v;
      if (i % 40 == 0) begin
        wr_cfg(1'b0, (i % 80 == 0) ? $urandom() : ($urandom() & 32'h00FF_FFFF));
        wr_cfg(1'b1, $urandom() & 32'h000F_FFFF);
      end
      case ($urandom() % 4)
        0: v = m_limit;
        1: v = m_limit + 32'd1;
        2: v = $urandom() & 32'h000F_FFFF;
        default: v = $urandom();
      endcase
      do_req(v, "rand");
      if ($urandom() % 3 == 0) begin
        @(negedge clk);
        chk("R8 rand idle", AW'(rsp_valid), AW'(0));
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule